// File: doc/BRIEF.md
# Scan-Line Interrupt Control Register

This block is one 32-bit control and status word that sits on a display timing path. Software programs a target scan line and an enable through a simple selected-write/combinational-read port. A timing generator supplies the current line number and a one-cycle pulse at the start of each line. When a pulse arrives while the line number equals the programmed target, a sticky event flag is set. The flag drives a level interrupt request whenever the enable is on.

The flag records every match, even while the enable is off. Software can poll it, or it can turn on the enable later and get an interrupt straight away. Software can only clear the flag, by writing 0 to its bit; writing 1 to that bit has no effect. If a match and a clear land in the same cycle, the match takes priority, so no line event is lost.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the target, enable and flag are all 0, so a read returns 0 and irq_o is low.
- R2: A write (sel_i=1, we_i=1) stores wdata_i[29:20] as the 10-bit target line, and a read returns it in bits 29:20.
- R3: The same write stores wdata_i[16] as the interrupt enable, and a read returns it in bit 16.
- R4: A cycle with line_start_i=1 and line_num_i equal to the stored target sets the flag (read bit 0) at that clock edge. A mismatching line number, or an equal line number without the strobe, leaves the flag unchanged.
- R5: The flag is set on a match whatever the value of the enable bit.
- R6: Once set, the flag stays 1 until a write with wdata_i[0]=0 clears it at that clock edge.
- R7: A write with wdata_i[0]=1 never changes the flag, whether it is 0 or 1.
- R8: Bits 31:30, 19:17 and 15:1 always read as 0, whatever value was written to them.
- R9: irq_o is high exactly when both the enable and the flag are 1, and it stays high as a level until one of them drops.
- R10: If a match and a clearing write fall in the same cycle, the flag ends up 1.
- R11: rdata_o shows the current register state when sel_i=1, and is 0 when sel_i=0. The target compare uses the target stored before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register selected by the address decode |
| we_i | input | 1 | Write strobe (valid when selected) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when not selected |
| line_num_i | input | 10 | Current scan line from the timing generator |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check four things on every cycle: the flag stays set unless a clearing write arrives, it never rises without a line match, a match always sets it (even when a clear is written in the same cycle), and the reserved bits and a held interrupt level behave correctly. Only the bench scenarios can show that the target and enable fields land in the right bit positions. The same is true for matches being ignored when the strobe is absent or the line differs, a sweep over the whole line range firing on exactly one line, and the interrupt appearing at once when the enable is set over a flag that is already pending.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LINE_W   = 10;
  localparam int unsigned TGT_LSB  = 20;
  localparam int unsigned TGT_MSB  = TGT_LSB + LINE_W - 1;
  localparam int unsigned EN_BIT   = 16;
  localparam int unsigned STAT_BIT = 0;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    line_t tgt;
    logic  en;
  } cfg_t;

  function automatic word_t pack_word(line_t tgt, logic en, logic stat);
    word_t w;
    w = '0;
    w[TGT_MSB:TGT_LSB] = tgt;
    w[EN_BIT]          = en;
    w[STAT_BIT]        = stat;
    return w;
  endfunction

  localparam word_t LIVE_MASK = pack_word('1, 1'b1, 1'b1);
endpackage

// File: rtl/slc_cfg_regs.sv
module slc_cfg_regs
  import scanline_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  word_t wdata_i,
  output cfg_t  cfg_o
);
  localparam word_t CFG_MASK = pack_word('1, 1'b1, 1'b0);

  logic unused_bits;
  assign unused_bits = ^(wdata_i & ~CFG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      cfg_o.tgt <= wdata_i[TGT_MSB:TGT_LSB];
      cfg_o.en  <= wdata_i[EN_BIT];
    end
  end
endmodule

// File: rtl/slc_line_cmp.sv
module slc_line_cmp #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] line_num_i,
  input  logic         line_start_i,
  input  logic [W-1:0] target_i,
  output logic         hit_o
);
  assign hit_o = line_start_i && (line_num_i == target_i);
endmodule

// File: rtl/slc_status_flag.sv
module slc_status_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);
  // set has priority so a coincident clear cannot drop an event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_o <= 1'b0;
    else if (set_i)  stat_o <= 1'b1;
    else if (clr_i)  stat_o <= 1'b0;
  end
endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import scanline_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              line_start_i,
  output logic              irq_o
);
  cfg_t  cfg_q;
  line_t tgt_q;
  logic  en_q;
  logic  stat_q;
  logic  wr;
  logic  clr;
  logic  hit;

  assign wr  = sel_i && we_i;
  assign clr = wr && !wdata_i[STAT_BIT];

  slc_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .wdata_i(wdata_i),
    .cfg_o  (cfg_q)
  );

  assign tgt_q = cfg_q.tgt;
  assign en_q  = cfg_q.en;

  slc_line_cmp #(.W(LINE_W)) u_cmp (
    .line_num_i  (line_num_i),
    .line_start_i(line_start_i),
    .target_i    (tgt_q),
    .hit_o       (hit)
  );

  slc_status_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (clr),
    .stat_o(stat_q)
  );

  assign rdata_o = sel_i ? pack_word(tgt_q, en_q, stat_q) : '0;
  assign irq_o   = en_q && stat_q;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk
  import scanline_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic              wr_stat_i,
  input logic              wr_en_i,
  input logic [LINE_W-1:0] line_num_i,
  input logic              line_start_i,
  input logic [LINE_W-1:0] tgt_q,
  input logic              stat_q,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o
);
  logic clr_w, dis_w, match_w;
  assign clr_w   = sel_i && we_i && !wr_stat_i;
  assign dis_w   = sel_i && we_i && !wr_en_i;
  assign match_w = line_start_i && (line_num_i == tgt_q);

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_w) |=> stat_q); // R6

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q && !match_w) |=> !stat_q); // R7

  AST_MATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_w |=> stat_q); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~LIVE_MASK) == '0); // R8

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_w && !dis_w) |=> irq_o); // R9
endmodule

bind scanline_irq_ctrl scanline_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .wr_stat_i   (wdata_i[0]),
  .wr_en_i     (wdata_i[16]),
  .line_num_i  (line_num_i),
  .line_start_i(line_start_i),
  .tgt_q       (tgt_q),
  .stat_q      (stat_q),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o)
);

// File: tb/test_scanline_irq_ctrl.sv
module test_scanline_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [9:0]  line_num_i = '0;
  logic        line_start_i = 1'b0;
  logic        irq_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural model state
  int m_tgt = 0;
  int m_en = 0;
  int m_stat = 0;

  always #2.5 clk_i = ~clk_i;

  scanline_irq_ctrl i_scanline_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .line_num_i(line_num_i),
    .line_start_i(line_start_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, compare outputs mid-cycle, advance model at the edge
  task automatic step(input logic s, input logic w, input logic [31:0] wd,
                      input int ln, input logic ls, input string tag);
    logic [31:0] exp_rd;
    bit hit;
    @(negedge clk_i);
    sel_i = s; we_i = w; wdata_i = wd; line_num_i = 10'(ln); line_start_i = ls;
    #1;
    exp_rd = s ? ((32'(m_tgt) << 20) | (32'(m_en) << 16) | 32'(m_stat)) : 32'h0;
    check({tag, " rdata"}, rdata_o, exp_rd);
    check({tag, " irq"}, {31'h0, irq_o}, {31'h0, (m_en != 0 && m_stat != 0)});
    @(posedge clk_i);
    hit = ls && (ln == m_tgt);
    if (s && w) begin
      m_tgt = int'(wd[29:20]);
      m_en  = int'(wd[16]);
    end
    if (hit) m_stat = 1;
    else if (s && w && !wd[0]) m_stat = 0;
  endtask

  function automatic logic [31:0] word(input int tgt, input int en, input int st);
    return (32'(tgt) << 20) | (32'(en) << 16) | 32'(st);
  endfunction

  initial begin
    #1;
    check("R1 rdata in reset", rdata_o, 32'h0);
    check("R1 irq in reset", {31'h0, irq_o}, 32'h0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, 0, 0, 0, 0, "R1 after reset");
    step(0, 0, 0, 0, 0, "R11 unselected");
    // all-ones write: R2 R3 R7 R8
    step(1, 1, 32'hFFFF_FFFF, 0, 0, "R2 R3 R8 write ones");
    step(1, 0, 0, 0, 0, "R2 R3 R7 R8 readback");
    step(1, 1, word(600, 1, 1) | 32'hC00E_FFFE, 0, 0, "R8 reserved write");
    step(1, 0, 0, 0, 0, "R2 readback 600");
    // match sets flag, irq level R4 R9
    step(1, 0, 0, 600, 1, "R4 match");
    step(1, 0, 0, 0, 0, "R4 R9 flag set");
    step(1, 0, 0, 0, 0, "R9 irq held");
    step(1, 1, word(600, 1, 1), 0, 0, "R7 write one keeps");
    step(1, 0, 0, 0, 0, "R7 R6 still set");
    step(1, 1, word(600, 1, 0), 0, 0, "R6 clear");
    step(1, 0, 0, 0, 0, "R6 R9 cleared");
    // enable off R5
    step(1, 1, word(5, 0, 1), 0, 0, "R3 disable");
    step(1, 0, 0, 5, 0, "R4 no strobe");
    step(1, 0, 0, 6, 1, "R4 wrong line");
    step(1, 0, 0, 5, 1, "R5 match disabled");
    step(1, 0, 0, 0, 0, "R5 flag set irq low");
    // enable over pending flag R9
    step(1, 1, word(5, 1, 1), 0, 0, "R9 enable pending");
    step(1, 0, 0, 0, 0, "R9 irq on");
    step(1, 1, word(5, 0, 1), 0, 0, "R9 disable");
    step(1, 0, 0, 0, 0, "R9 irq off");
    // set wins over clear R10
    step(1, 1, word(5, 1, 0), 5, 1, "R10 collision");
    step(1, 0, 0, 0, 0, "R10 flag kept");
    // compare uses old target R11
    step(1, 1, word(9, 1, 0), 9, 1, "R11 old target");
    step(1, 0, 0, 0, 0, "R11 no set");
    // full sweep R4
    step(1, 1, word(700, 1, 0), 0, 0, "R4 sweep setup");
    for (int i = 0; i < 1024; i++) begin
      step((i % 2) == 0, 0, 0, i, 1, "R4 sweep");
      if (i == 800) step(1, 1, word(700, 1, 0), 0, 0, "R6 sweep clear");
    end
    step(1, 0, 0, 0, 0, "R4 sweep end");
    // reset mid-run R1
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_tgt = 0; m_en = 0; m_stat = 0;
    sel_i = 1'b1; we_i = 1'b0;
    #1;
    check("R1 async reset rdata", rdata_o, 32'h0);
    check("R1 async reset irq", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1, 0, 0, 0, 0, "R1 post reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule